// File: doc/BRIEF.md
# Torus Link-Rule Installer and Checker

This block sets up the link restrictions that a deterministically routed two-dimensional torus needs so that routes cannot circle the wrap-around rings. It holds one rule slice per router, laid out as a grid of `COLS` by `ROWS` nodes that talk only to their four neighbours, plus a shared lockstep sequencer. After reset every row has one blocked horizontal link, placed in a staggered pattern, and every column has its wrap-around vertical link blocked. A single `start` pulse then runs two checks, once per reset. The first is a row-parallel flood of "broken link seen" knowledge, which lifts a row's horizontal rule when a real fault already cuts that ring. The second is a flag-flooding route test per column, which drops a wrap-around rule when the router above the link cannot otherwise be reached.

When the checks finish, the final rule set is handed on as per-port allow masks for a queried destination. A blocked link is treated as open when the destination is at either of its ends, and a router that crosses a blocked link into the destination reports that its turn rule is to be ignored. The downstream corner-rule logic may also install extra unchecked link blocks through a fix-up request port.

Top module: `lr_torus_rules`

## Requirements
- R1: While reset is held and right after it, `done` is 0, every bit of `hrule` (one per row) is 1 and every bit of `vrule` (one per column) is 1.
- R2: Node n sits at column x = n mod COLS and row y = n / COLS; row 0 is the top row and north of row 0 wraps to row ROWS-1. In row y the default blocked horizontal link joins column (y mod COLS) to its east neighbour. In column x the default blocked vertical link is the wrap link between rows ROWS-1 and 0. `port_ok` bit 4n+d is the allow bit of port d of node n, with d = 0 north, 1 east, 2 south, 3 west.
- R3: After the checks, `hrule[y]` is 0 exactly when at least one horizontal link of row y is faulty (`flt_e[n]` marks the link from node n to its east neighbour). All rows are handled at once.
- R4: The vertical rules are checked column by column, in ascending order, after the horizontal rules have been settled. Column x floods from node (x,0) over links that are neither faulty nor blocked by the rules in force at that moment. `vrule[x]` becomes 0 exactly when node (x,ROWS-1) is not reached. `flt_s[n]` marks the link from node n to its south neighbour.
- R5: `done` rises COLS+1+COLS*(ROWS*COLS+1) clock edges after the edge that samples `start`, and then stays high.
- R6: The checks run once per reset. A `start` pulse after `done` leaves `done`, `hrule` and `vrule` unchanged, even if the faults have changed.
- R7: A fix-up request (`fix_valid`, node `fix_x`/`fix_y`, port `fix_dir` with the R2 port encoding) blocks that link at both of its ends only while `done` is 1. A request made before that has no effect. Fix-ups never change `hrule` or `vrule`.
- R8: One edge after a query of destination (`q_x`,`q_y`), `port_ok` bit 4n+d is 1 when the link on that port is not faulty and is either not blocked or has the destination at one of its two ends.
- R9: One edge after a query, `turn_ign[n]` is 1 exactly when some port of node n has a non-faulty blocked link whose far end is the destination.
- R10: A port whose link is faulty always reads 0 in `port_ok` one edge later, whatever the destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins the rule checks |
| flt_e | input | COLS*ROWS | Bit n: link from node n to its east neighbour is faulty |
| flt_s | input | COLS*ROWS | Bit n: link from node n to its south neighbour is faulty |
| fix_valid | input | 1 | Fix-up link block request |
| fix_x | input | XW | Column of the requesting node |
| fix_y | input | YW | Row of the requesting node |
| fix_dir | input | 2 | Port of the link to block (0 N, 1 E, 2 S, 3 W) |
| q_x | input | XW | Column of the queried destination |
| q_y | input | YW | Row of the queried destination |
| done | output | 1 | Checks complete, rules final |
| hrule | output | ROWS | Row y horizontal rule still in force |
| vrule | output | COLS | Column x wrap-around rule still in force |
| port_ok | output | 4*COLS*ROWS | Per-node, per-port allow mask for the queried destination |
| turn_ign | output | COLS*ROWS | Per-node turn-rule ignore flag for the queried destination |

## Verification
The assertions assume that the router coordinates are constant and inside the grid. They also assume that `flt_e` and `flt_s` stay still from `start` until `done`, since the broadcast and the flood read them cycle by cycle. The bench changes faults only while reset is held, or after `done` when it checks that a second `start` is ignored. It queries only coordinates inside the grid. The fault patterns include a row with a broken link and a horizontal cut through every column. This cut forces the first wrap-around rule to be dropped and lets the second column's check succeed through the link the first one opened.

// File: rtl/lr_pkg.sv
package lr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HB_INIT,
    PH_HB_RUN,
    PH_HB_LATCH,
    PH_VC_INIT,
    PH_VC_RUN,
    PH_VC_EVAL,
    PH_DONE
  } phase_t;

  localparam int DIR_N = 0;
  localparam int DIR_E = 1;
  localparam int DIR_S = 2;
  localparam int DIR_W = 3;
  localparam int NDIR  = 4;
endpackage

// File: rtl/lr_seq.sv
module lr_seq #(
  parameter int COLS = 4,
  parameter int ROWS = 4,
  parameter int XW   = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  output lr_pkg::phase_t ph,
  output logic [XW-1:0]  col,
  output logic           done
);
  import lr_pkg::*;

  localparam int NODES = COLS * ROWS;
  localparam int SW    = $clog2(NODES) + 1;

  logic [SW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= PH_IDLE;
      cnt <= '0;
      col <= '0;
    end else begin
      unique case (ph)
        PH_IDLE:     if (start) ph <= PH_HB_INIT;
        PH_HB_INIT:  begin ph <= PH_HB_RUN; cnt <= '0; end
        PH_HB_RUN:   if (cnt == SW'(COLS - 2)) ph <= PH_HB_LATCH;
                     else cnt <= cnt + 1'b1;
        PH_HB_LATCH: begin ph <= PH_VC_INIT; col <= '0; end
        PH_VC_INIT:  begin ph <= PH_VC_RUN; cnt <= '0; end
        PH_VC_RUN:   if (cnt == SW'(NODES - 2)) ph <= PH_VC_EVAL;
                     else cnt <= cnt + 1'b1;
        PH_VC_EVAL:  if (col == XW'(COLS - 1)) ph <= PH_DONE;
                     else begin col <= col + 1'b1; ph <= PH_VC_INIT; end
        PH_DONE:     ph <= PH_DONE;
        default:     ph <= PH_IDLE;
      endcase
    end
  end

  assign done = (ph == PH_DONE);

  // R5 / R6: completion is final, a later start cannot reopen the checks
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  // R4: the column under test never leaves the grid
  a_r4_col_range: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_VC_RUN) |-> (int'(col) < COLS));
endmodule

// File: rtl/lr_node.sv
module lr_node #(
  parameter int COLS = 4,
  parameter int ROWS = 4,
  parameter int XW   = 2,
  parameter int YW   = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  lr_pkg::phase_t ph,
  input  logic [XW-1:0]  vc_col,
  input  logic [XW-1:0]  my_x,
  input  logic [YW-1:0]  my_y,
  input  logic [3:0]     flt,        // link faults by port N,E,S,W
  input  logic           nb_blk_n,   // north neighbour blocks its south link
  input  logic           nb_blk_w,   // west neighbour blocks its east link
  input  logic           bk_nb_e,
  input  logic           bk_nb_w,
  input  logic [3:0]     vld_nb,
  input  logic           fix_e_set,
  input  logic           fix_s_set,
  input  logic [XW-1:0]  q_x,
  input  logic [YW-1:0]  q_y,
  output logic           bk_o,
  output logic           vld_o,
  output logic           blk_e_o,
  output logic           blk_s_o,
  output logic           rule_h_o,
  output logic           rule_v_o,
  output logic [3:0]     port_ok_o,
  output logic           turn_ign_o
);
  import lr_pkg::*;

  logic is_hk, is_vk;
  logic fix_e, fix_s;
  logic [3:0] blk, open_l, dst_nb;
  logic dst_me;
  logic [XW-1:0] nx_e, nx_w;
  logic [YW-1:0] ny_n, ny_s;

  // R2: staggered horizontal keeper and bottom-row wrap keeper
  assign is_hk = (int'(my_x) == (int'(my_y) % COLS));
  assign is_vk = (my_y == YW'(ROWS - 1));

  assign blk_e_o = rule_h_o | fix_e;
  assign blk_s_o = rule_v_o | fix_s;
  assign blk     = {nb_blk_w, blk_s_o, blk_e_o, nb_blk_n};
  assign open_l  = ~flt & ~blk;

  // R3: row broadcast of broken-link knowledge over healthy links
  always_ff @(posedge clk) begin
    if (rst) begin
      bk_o     <= 1'b0;
      rule_h_o <= is_hk;
    end else begin
      if (ph == PH_HB_INIT)
        bk_o <= flt[DIR_E] | flt[DIR_W];
      else if (ph == PH_HB_RUN)
        bk_o <= bk_o | (bk_nb_e & ~flt[DIR_E]) | (bk_nb_w & ~flt[DIR_W]);
      if (ph == PH_HB_LATCH && bk_o)
        rule_h_o <= 1'b0;
    end
  end

  // R4: flood from the top end of the column's wrap link
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o    <= 1'b0;
      rule_v_o <= is_vk;
    end else begin
      if (ph == PH_VC_INIT)
        vld_o <= (my_x == vc_col) && (my_y == '0);
      else if (ph == PH_VC_RUN)
        vld_o <= vld_o | (|(vld_nb & open_l));
      if (ph == PH_VC_EVAL && is_vk && (my_x == vc_col) && !vld_o)
        rule_v_o <= 1'b0;
    end
  end

  // R7: unchecked fix-up blocks, accepted only after the checks
  always_ff @(posedge clk) begin
    if (rst) begin
      fix_e <= 1'b0;
      fix_s <= 1'b0;
    end else if (ph == PH_DONE) begin
      if (fix_e_set) fix_e <= 1'b1;
      if (fix_s_set) fix_s <= 1'b1;
    end
  end

  // R8 / R9 / R10: destination-aware allow mask
  assign nx_e = (my_x == XW'(COLS - 1)) ? '0 : my_x + 1'b1;
  assign nx_w = (my_x == '0) ? XW'(COLS - 1) : my_x - 1'b1;
  assign ny_n = (my_y == '0) ? YW'(ROWS - 1) : my_y - 1'b1;
  assign ny_s = (my_y == YW'(ROWS - 1)) ? '0 : my_y + 1'b1;

  assign dst_me = (q_x == my_x) && (q_y == my_y);
  assign dst_nb[DIR_N] = (q_x == my_x) && (q_y == ny_n);
  assign dst_nb[DIR_E] = (q_x == nx_e) && (q_y == my_y);
  assign dst_nb[DIR_S] = (q_x == my_x) && (q_y == ny_s);
  assign dst_nb[DIR_W] = (q_x == nx_w) && (q_y == my_y);

  always_ff @(posedge clk) begin
    if (rst) begin
      port_ok_o  <= '0;
      turn_ign_o <= 1'b0;
    end else begin
      port_ok_o  <= ~flt & (~blk | {4{dst_me}} | dst_nb);
      turn_ign_o <= |(~flt & blk & dst_nb);
    end
  end

  a_r4_vrule_monotone: assert property (@(posedge clk) disable iff (rst)
    !rule_v_o |=> !rule_v_o);

  a_r3_hrule_latch_only: assert property (@(posedge clk) disable iff (rst)
    (ph != PH_HB_LATCH) |=> $stable(rule_h_o));

  a_r10_fault_closed: assert property (@(posedge clk) disable iff (rst)
    (flt != 4'b0) |=> ((port_ok_o & $past(flt)) == 4'b0));

  a_r7_fix_after_done: assert property (@(posedge clk) disable iff (rst)
    (ph != PH_DONE) |=> ($stable(fix_e) && $stable(fix_s)));
endmodule

// File: rtl/lr_torus_rules.sv
module lr_torus_rules #(
  parameter  int COLS = 4,
  parameter  int ROWS = 4,
  localparam int XW   = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int YW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [COLS*ROWS-1:0]   flt_e,
  input  logic [COLS*ROWS-1:0]   flt_s,
  input  logic                   fix_valid,
  input  logic [XW-1:0]          fix_x,
  input  logic [YW-1:0]          fix_y,
  input  logic [1:0]             fix_dir,
  input  logic [XW-1:0]          q_x,
  input  logic [YW-1:0]          q_y,
  output logic                   done,
  output logic [ROWS-1:0]        hrule,
  output logic [COLS-1:0]        vrule,
  output logic [4*COLS*ROWS-1:0] port_ok,
  output logic [COLS*ROWS-1:0]   turn_ign
);
  import lr_pkg::*;

  localparam int NODES = COLS * ROWS;

  phase_t        ph;
  logic [XW-1:0] vc_col;
  logic [NODES-1:0] bk, vld, blk_e, blk_s, rule_h, rule_v, fe_req, fs_req;

  lr_seq #(.COLS(COLS), .ROWS(ROWS), .XW(XW)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .ph(ph), .col(vc_col), .done(done)
  );

  for (genvar gy = 0; gy < ROWS; gy++) begin : g_row
    for (genvar gx = 0; gx < COLS; gx++) begin : g_col
      localparam int ID = gy * COLS + gx;
      localparam int IN = ((gy + ROWS - 1) % ROWS) * COLS + gx;
      localparam int IS = ((gy + 1) % ROWS) * COLS + gx;
      localparam int IE = gy * COLS + (gx + 1) % COLS;
      localparam int IW = gy * COLS + (gx + COLS - 1) % COLS;

      logic hit_me, hit_e, hit_s;
      assign hit_me = (fix_x == XW'(gx)) && (fix_y == YW'(gy));
      assign hit_e  = (fix_x == XW'((gx + 1) % COLS)) && (fix_y == YW'(gy));
      assign hit_s  = (fix_x == XW'(gx)) && (fix_y == YW'((gy + 1) % ROWS));

      // a fix-up names a port; the link owner is the node on its west / north end
      assign fe_req[ID] = fix_valid && ((hit_me && fix_dir == 2'd1) ||
                                        (hit_e  && fix_dir == 2'd3));
      assign fs_req[ID] = fix_valid && ((hit_me && fix_dir == 2'd2) ||
                                        (hit_s  && fix_dir == 2'd0));

      lr_node #(.COLS(COLS), .ROWS(ROWS), .XW(XW), .YW(YW)) u_node (
        .clk(clk), .rst(rst), .ph(ph), .vc_col(vc_col),
        .my_x(XW'(gx)), .my_y(YW'(gy)),
        .flt({flt_e[IW], flt_s[ID], flt_e[ID], flt_s[IN]}),
        .nb_blk_n(blk_s[IN]), .nb_blk_w(blk_e[IW]),
        .bk_nb_e(bk[IE]), .bk_nb_w(bk[IW]),
        .vld_nb({vld[IW], vld[IS], vld[IE], vld[IN]}),
        .fix_e_set(fe_req[ID]), .fix_s_set(fs_req[ID]),
        .q_x(q_x), .q_y(q_y),
        .bk_o(bk[ID]), .vld_o(vld[ID]),
        .blk_e_o(blk_e[ID]), .blk_s_o(blk_s[ID]),
        .rule_h_o(rule_h[ID]), .rule_v_o(rule_v[ID]),
        .port_ok_o(port_ok[4*ID +: 4]), .turn_ign_o(turn_ign[ID])
      );
    end
    assign hrule[gy] = rule_h[gy * COLS + (gy % COLS)];
  end

  for (genvar cx = 0; cx < COLS; cx++) begin : g_vout
    assign vrule[cx] = rule_v[(ROWS - 1) * COLS + cx];
  end
endmodule

// File: tb/tb_lr_torus_rules.sv
`timescale 1ns/1ps
module tb_lr_torus_rules;
  localparam int COLS = 4;
  localparam int ROWS = 4;
  localparam int N    = COLS * ROWS;
  localparam int XW   = 2;
  localparam int YW   = 2;

  logic clk = 1'b0;
  logic rst, start, fix_valid, done;
  logic [N-1:0] flt_e, flt_s, turn_ign;
  logic [XW-1:0] fix_x, q_x;
  logic [YW-1:0] fix_y, q_y;
  logic [1:0] fix_dir;
  logic [ROWS-1:0] hrule;
  logic [COLS-1:0] vrule;
  logic [4*N-1:0] port_ok;

  always #2 clk = ~clk;

  lr_torus_rules #(.COLS(COLS), .ROWS(ROWS)) dut (
    .clk(clk), .rst(rst), .start(start), .flt_e(flt_e), .flt_s(flt_s),
    .fix_valid(fix_valid), .fix_x(fix_x), .fix_y(fix_y), .fix_dir(fix_dir),
    .q_x(q_x), .q_y(q_y), .done(done), .hrule(hrule), .vrule(vrule),
    .port_ok(port_ok), .turn_ign(turn_ign)
  );

  int checks = 0;
  int errors = 0;

  logic [ROWS-1:0] hexp;
  logic [COLS-1:0] vexp;
  logic [N-1:0]    fixE, fixS;

  typedef struct {
    logic [4*N-1:0] ports;
    logic [N-1:0]   turn;
    string          tag;
  } sb_t;
  sb_t sbq[$];
  sb_t it;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int nbr(int n, int d);
    int x = n % COLS;
    int y = n / COLS;
    case (d)
      0: return ((y + ROWS - 1) % ROWS) * COLS + x;
      1: return y * COLS + (x + 1) % COLS;
      2: return ((y + 1) % ROWS) * COLS + x;
      default: return y * COLS + (x + COLS - 1) % COLS;
    endcase
  endfunction

  function automatic bit fltd(int n, int d);
    case (d)
      0: return flt_s[nbr(n, 0)];
      1: return flt_e[n];
      2: return flt_s[n];
      default: return flt_e[nbr(n, 3)];
    endcase
  endfunction

  function automatic bit blkE(int n);
    int x = n % COLS;
    int y = n / COLS;
    return (x == y % COLS && hexp[y]) || fixE[n];
  endfunction

  function automatic bit blkS(int n);
    int x = n % COLS;
    int y = n / COLS;
    return (y == ROWS - 1 && vexp[x]) || fixS[n];
  endfunction

  function automatic bit blkd(int n, int d);
    case (d)
      0: return blkS(nbr(n, 0));
      1: return blkE(n);
      2: return blkS(n);
      default: return blkE(nbr(n, 3));
    endcase
  endfunction

  // reference rule outcome from R3 and R4
  task automatic model_rules();
    for (int y = 0; y < ROWS; y++) begin
      hexp[y] = 1'b1;
      for (int x = 0; x < COLS; x++) if (flt_e[y*COLS+x]) hexp[y] = 1'b0;
    end
    vexp = '1;
    for (int c = 0; c < COLS; c++) begin
      logic [N-1:0] reach, nxt;
      reach = '0;
      reach[c] = 1'b1;
      for (int s = 0; s < N - 1; s++) begin
        nxt = reach;
        for (int n = 0; n < N; n++)
          if (reach[n])
            for (int d = 0; d < 4; d++)
              if (!fltd(n, d) && !blkd(n, d)) nxt[nbr(n, d)] = 1'b1;
        reach = nxt;
      end
      if (!reach[(ROWS-1)*COLS + c]) vexp[c] = 1'b0;
    end
  endtask

  task automatic query(int qx, int qy, string tag);
    sb_t e;
    int q = qy * COLS + qx;
    @(negedge clk);
    q_x = XW'(qx);
    q_y = YW'(qy);
    e.ports = '0;
    e.turn  = '0;
    e.tag   = tag;
    for (int n = 0; n < N; n++)
      for (int d = 0; d < 4; d++) begin
        bit nb = (nbr(n, d) == q);
        bit me = (n == q);
        e.ports[4*n+d] = !fltd(n, d) && (!blkd(n, d) || me || nb);
        if (!fltd(n, d) && blkd(n, d) && nb) e.turn[n] = 1'b1;
      end
    @(posedge clk);
    sbq.push_back(e);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (sbq.size() != 0) begin
      it = sbq.pop_front();
      chk(it.tag, 64'(port_ok), 64'(it.ports), "port_ok");
      chk(it.tag, 64'(turn_ign), 64'(it.turn), "turn_ign");
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; start = 1'b0; fix_valid = 1'b0;
    fix_x = '0; fix_y = '0; fix_dir = '0; q_x = '0; q_y = '0;
    fixE = '0; fixS = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic pulse_start(output int lat);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 1000) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
  endtask

  task automatic fix_req(int fx, int fy, int fd, bit expect_taken);
    @(negedge clk);
    fix_valid = 1'b1; fix_x = XW'(fx); fix_y = YW'(fy); fix_dir = 2'(fd);
    @(posedge clk);
    @(negedge clk);
    fix_valid = 1'b0;
    if (expect_taken) begin
      int n = fy * COLS + fx;
      case (fd)
        0: fixS[nbr(n, 0)] = 1'b1;
        1: fixE[n] = 1'b1;
        2: fixS[n] = 1'b1;
        default: fixE[nbr(n, 3)] = 1'b1;
      endcase
    end
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  task automatic run_all();
    int lat;
    logic [ROWS-1:0] h_hold;
    logic [COLS-1:0] v_hold;

    // Scenario A: fault-free torus
    flt_e = '0; flt_s = '0;
    do_reset();
    chk("R1", 64'(done), 64'(0), "done after reset");
    chk("R1", 64'(hrule), 64'({ROWS{1'b1}}), "hrule after reset");
    chk("R1", 64'(vrule), 64'({COLS{1'b1}}), "vrule after reset");
    pulse_start(lat);
    chk("R5", 64'(lat), 64'(COLS + 1 + COLS * (N + 1)), "done latency");
    model_rules();
    chk("R3", 64'(hrule), 64'(hexp), "hrule no faults");
    chk("R4", 64'(vrule), 64'(vexp), "vrule no faults");
    query(1, 2, "R2");   // destination away from every blocked link
    query(1, 0, "R8");   // endpoint of row 0 rule and column 1 wrap rule
    query(0, 3, "R9");   // far end of row 3 rule and column 0 wrap rule
    drain();

    // Scenario B: row 1 broken, every column cut between rows 1 and 2
    flt_e = '0; flt_s = '0;
    flt_e[1*COLS + 2] = 1'b1;
    for (int x = 0; x < COLS; x++) flt_s[1*COLS + x] = 1'b1;
    do_reset();
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    fix_req(2, 0, 2, 1'b0);   // before done: must be dropped (R7)
    while (!done) @(negedge clk);
    model_rules();
    chk("R3", 64'(hrule), 64'(hexp), "hrule with row fault");
    chk("R4", 64'(vrule), 64'(vexp), "vrule with column cut");
    chk("R4", 64'(vrule[0]), 64'(0), "first wrap rule dropped");
    query(2, 1, "R10");
    query(3, 0, "R8");
    query(0, 0, "R9");
    query(2, 2, "R7");        // early fix-up must not show
    drain();

    // R6: second start after done is ignored
    h_hold = hrule;
    v_hold = vrule;
    flt_e[0] = 1'b1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (100) @(negedge clk);
    chk("R6", 64'(done), 64'(1), "done after restart attempt");
    chk("R6", 64'(hrule), 64'(h_hold), "hrule after restart attempt");
    chk("R6", 64'(vrule), 64'(v_hold), "vrule after restart attempt");
    flt_e[0] = 1'b0;

    // R7: fix-ups after done block both ends, rules untouched
    fix_req(1, 1, 0, 1'b1);
    fix_req(0, 2, 3, 1'b1);
    query(3, 2, "R7");
    query(1, 0, "R7");
    query(3, 2, "R8");
    drain();
    chk("R7", 64'(hrule), 64'(h_hold), "hrule after fix-ups");
    chk("R7", 64'(vrule), 64'(v_hold), "vrule after fix-ups");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R5 watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule